// File: doc/BRIEF.md
# Frame-Aligned Elastic Store Buffer

This block is a bit-serial elastic buffer for a framed 2.048 Mbit/s link with 256-bit frames. A line-side writer stores one bit per write strobe and a system-side reader takes one bit per read strobe. Both strobes are in the same clock domain. The small rate difference between the two streams is absorbed in a two-frame store. When the store would underflow or overflow, one whole frame is repeated or dropped, so the reader never loses frame alignment. A write that carries the frame-start marker always lands on bit 0 of a frame slot. If the write pointer is not already on a boundary, it jumps to the start of the next slot. The read side raises its own frame-start marker on every bit read from position 0 of a slot.

Four control inputs shape the behaviour:
- An enable input selects between the store and a direct bypass.
- A minimum-delay input shrinks the usable depth to 32 bits.
- Two edge-triggered commands move the read pointer. The align command sets a half-frame spacing, and only when the pointers are too close. The reset command sets a full-frame spacing, which places the two pointers in opposite frame slots.

In every requirement below, "fill" means the number of bits that have been written but not yet read. It is counted modulo the 512-bit storage.

Top module: `e1_elastic_store`

## Requirements
- R1: After the main reset (rst_n low), fill is 256, meaning the pointers are in opposite frames. rd_bit, rd_fs, slip_rep and slip_del are all 0. The storage is cleared, so reads return 0 until written data reaches the reader.
- R2: With enable at 0, rd_bit equals wr_bit and rd_fs equals wr_fs combinationally, in every input pattern. slip_rep and slip_del stay 0 in the cycle after any cycle with enable at 0.
- R3: In normal mode, with enable at 1 and one write and one read in every cycle after reset, the bit shown after read n is the bit written by write n-256. It is 0 for n below 256.
- R4: rd_fs is 1 in the cycle after a read whose address is bit 0 of a frame slot, and 0 otherwise.
- R5: A read strobe that arrives when fill is 0 is a repeat slip. The read pointer first moves back by one frame, or by 16 bits in minimum-delay mode, and then reads. slip_rep is high for exactly the next cycle.
- R6: A write strobe that arrives when fill is at the limit is a delete slip. The limit is 511 in normal mode and 31 in minimum-delay mode. The read pointer moves forward by one frame, or by 16 bits in minimum-delay mode, so the oldest data is skipped. slip_del is high for exactly the next cycle.
- R7: With min_dly at 1, the usable depth is 32 bits and the slip distance is 16. The frame markers still follow the true 256-bit frame boundary.
- R8: A 0-to-1 edge of align_cmd sets fill to 128 if fill was below 128. In minimum-delay mode the threshold and target are both 16. If fill is already at or above the threshold, the edge does nothing. Holding align_cmd high does nothing further, and a new align needs a fresh edge.
- R9: A 0-to-1 edge of reset_cmd sets fill to 256, or to 16 in minimum-delay mode. A read strobe in that same cycle is discarded, and rd_bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | 1 = use the store, 0 = bypass |
| min_dly | input | 1 | 1 = 32-bit minimum-delay depth |
| align_cmd | input | 1 | Align command, acts on a rising edge |
| reset_cmd | input | 1 | Pointer reset command, acts on a rising edge |
| wr_en | input | 1 | Write strobe |
| wr_bit | input | 1 | Write data bit |
| wr_fs | input | 1 | Marks the written bit as bit 0 of a frame |
| rd_en | input | 1 | Read strobe |
| rd_bit | output | 1 | Read data bit |
| rd_fs | output | 1 | Marks the read bit as bit 0 of a frame |
| slip_rep | output | 1 | One-cycle flag: a frame was repeated |
| slip_del | output | 1 | One-cycle flag: a frame was deleted |

## Verification
A wrong pointer spacing shows up on the read data as a constant offset. The bench streams a position-coded pattern, so a spacing off by a single bit corrupts data on the first read after written data arrives, at most 256 reads after the event. A wrong fill count shows up on slip_rep or slip_del. These flags are checked against the exact strobe index at which the fill must reach 0 or the limit, so an early or late slip is seen in that same cycle. Frame-slot errors appear on rd_fs, which is checked on every read.

// File: rtl/e1_elastic_store.sv
module e1_elastic_store #(
  parameter int FRAME_BITS = 256,
  parameter int MIN_DEPTH  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic min_dly,
  input  logic align_cmd,
  input  logic reset_cmd,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic wr_fs,
  input  logic rd_en,
  output logic rd_bit,
  output logic rd_fs,
  output logic slip_rep,
  output logic slip_del
);
  localparam int DEPTH = 2 * FRAME_BITS;
  localparam int AW    = $clog2(DEPTH);
  localparam int FW    = $clog2(FRAME_BITS);
  localparam logic [AW-1:0] FRAME     = AW'(FRAME_BITS);
  localparam logic [AW-1:0] HALF_FR   = AW'(FRAME_BITS / 2);
  localparam logic [AW-1:0] SHORT     = AW'(MIN_DEPTH / 2);
  localparam logic [AW-1:0] FULL_LIM  = AW'(DEPTH - 1);
  localparam logic [AW-1:0] SHORT_LIM = AW'(MIN_DEPTH - 1);

  logic          mem [DEPTH];
  logic [AW-1:0] wp, rp, fill, wa, wp_n, ra, rp_n;
  logic [AW-1:0] slip_amt, lim, align_tgt, rst_tgt;
  logic          q, q_fs, align_q, reset_q;
  logic          rst_go, align_go, rep, del, rd_ok;

  assign fill      = wp - rp;
  assign slip_amt  = min_dly ? SHORT : FRAME;
  assign lim       = min_dly ? SHORT_LIM : FULL_LIM;
  assign align_tgt = min_dly ? SHORT : HALF_FR;
  assign rst_tgt   = min_dly ? SHORT : FRAME;

  assign rst_go   = reset_cmd & ~reset_q;
  assign align_go = align_cmd & ~align_q & ~rst_go & (fill < align_tgt);
  assign rd_ok    = rd_en & ~rst_go & ~align_go;
  assign rep      = rd_ok & (fill == '0);
  assign del      = wr_en & ~rst_go & ~align_go & (fill >= lim);

  assign wa   = (wr_fs && wp[FW-1:0] != '0) ? {~wp[FW], {FW{1'b0}}} : wp;
  assign wp_n = wr_en ? wa + AW'(1) : wp;
  assign ra   = rep ? rp - slip_amt : rp;

  always_comb begin
    if (rst_go)        rp_n = wp_n - rst_tgt;
    else if (align_go) rp_n = wp_n - align_tgt;
    else begin
      rp_n = rd_ok ? ra + AW'(1) : rp;
      if (del) rp_n = rp_n + slip_amt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= FRAME;
      q        <= 1'b0;
      q_fs     <= 1'b0;
      align_q  <= 1'b0;
      reset_q  <= 1'b0;
      slip_rep <= 1'b0;
      slip_del <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 1'b0;
    end else begin
      align_q  <= align_cmd;
      reset_q  <= reset_cmd;
      wp       <= wp_n;
      rp       <= rp_n;
      slip_rep <= enable & rep;
      slip_del <= enable & del;
      q_fs     <= rd_ok & (ra[FW-1:0] == '0);
      if (rd_ok) q <= mem[ra];
      if (wr_en) mem[wa] <= wr_bit;
    end
  end

  assign rd_bit = enable ? q : wr_bit;
  assign rd_fs  = enable ? q_fs : wr_fs;

  // R5
  slip_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip_rep |=> !slip_rep);
  // R6
  slip_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(slip_rep && slip_del));
  // R8
  align_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_go |=> fill == $past(align_tgt));
  // R9
  rst_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_go |=> fill == $past(rst_tgt));
  // R4
  fs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_fs |-> $past(rd_en));
  // R2
  bypass_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !slip_rep && !slip_del);
endmodule

// File: tb/e1_elastic_store_tb.sv
module e1_elastic_store_tb;
  logic clk = 1'b0;
  logic rst_n, enable, min_dly, align_cmd, reset_cmd;
  logic wr_en, wr_bit, wr_fs, rd_en;
  logic rd_bit, rd_fs, slip_rep, slip_del;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  e1_elastic_store u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .min_dly(min_dly),
    .align_cmd(align_cmd), .reset_cmd(reset_cmd), .wr_en(wr_en),
    .wr_bit(wr_bit), .wr_fs(wr_fs), .rd_en(rd_en), .rd_bit(rd_bit),
    .rd_fs(rd_fs), .slip_rep(slip_rep), .slip_del(slip_del)
  );

  // {wr_en, rd_en, wr_bit, wr_fs, exp_bit, exp_fs}
  localparam logic [5:0] BYP [8] = '{
    6'b101010, 6'b010101, 6'b111111, 6'b000000,
    6'b110000, 6'b001010, 6'b100101, 6'b011111
  };

  function automatic logic pat(int n);
    logic [31:0] v = n;
    return v[0] ^ v[2] ^ v[5];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic strobes(input logic w, input logic r, input logic b, input logic f);
    wr_en = w; rd_en = r; wr_bit = b; wr_fs = f;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; enable = 1'b1; min_dly = 1'b0;
    align_cmd = 1'b0; reset_cmd = 1'b0;
    strobes(0, 0, 0, 0);
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic stream(input int n_len, input int lag, input int fs_at, input string req);
    for (int n = 0; n < n_len; n++) begin
      strobes(1, 1, pat(n), (n % 256) == 0);
      tick();
      chk({req, " data"}, rd_bit, n < lag ? 0 : pat(n - lag));
      chk("R4 rd_fs", rd_fs, (n % 256) == fs_at);
      chk({req, " no slip"}, slip_rep | slip_del, 0);
    end
    strobes(0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1
    chk("R1 rd_bit", rd_bit, 0);
    chk("R1 rd_fs", rd_fs, 0);
    chk("R1 slip_rep", slip_rep, 0);
    chk("R1 slip_del", slip_del, 0);

    // R2 bypass vectors
    enable = 1'b0;
    for (int i = 0; i < 8; i++) begin
      strobes(BYP[i][5], BYP[i][4], BYP[i][3], BYP[i][2]);
      #1;
      chk("R2 rd_bit", rd_bit, BYP[i][1]);
      chk("R2 rd_fs", rd_fs, BYP[i][0]);
      tick();
      chk("R2 slips", slip_rep | slip_del, 0);
    end

    // R3 R4 R1 steady stream, two-frame delay
    do_reset();
    stream(600, 256, 0, "R3");

    // R5 repeat slip: reads only
    do_reset();
    for (int k = 0; k < 259; k++) begin
      strobes(0, 1, 0, 0);
      tick();
      chk("R5 slip_rep", slip_rep, k == 256);
      if (k == 256) chk("R5 rd_fs", rd_fs, 1);
    end

    // R6 delete slip: writes only
    do_reset();
    for (int k = 0; k < 258; k++) begin
      strobes(1, 0, pat(k), k == 0);
      tick();
      chk("R6 slip_del", slip_del, k == 255);
    end
    strobes(0, 1, 0, 0);
    tick();
    chk("R6 skipped frame data", rd_bit, pat(0));
    chk("R6 skipped frame fs", rd_fs, 1);

    // R7 R9 minimum-delay mode
    do_reset();
    min_dly = 1'b1;
    reset_cmd = 1'b1;
    tick();
    reset_cmd = 1'b0;
    chk("R9 no read on command", rd_bit, 0);
    stream(80, 16, 16, "R7");
    for (int k = 0; k < 17; k++) begin
      strobes(1, 0, 0, 0);
      tick();
      chk("R7 min slip_del", slip_del, k == 15);
    end
    for (int k = 0; k < 19; k++) begin
      strobes(0, 1, 0, 0);
      tick();
      chk("R7 min slip_rep", slip_rep, k == 17);
    end
    strobes(0, 0, 0, 0);
    min_dly = 1'b0;

    // R8 align ignored when spacing already large
    do_reset();
    align_cmd = 1'b1;
    tick();
    align_cmd = 1'b0;
    stream(300, 256, 0, "R8 no-op");

    // R8 align acts when spacing small, once per edge
    do_reset();
    for (int k = 0; k < 200; k++) begin
      strobes(0, 1, 0, 0);
      tick();
    end
    strobes(0, 0, 0, 0);
    align_cmd = 1'b1;
    tick();
    for (int n = 0; n < 200; n++) begin
      if (n == 50) align_cmd = 1'b0;
      if (n == 100) align_cmd = 1'b1;
      strobes(1, 1, pat(n), (n % 256) == 0);
      tick();
      chk("R8 data", rd_bit, n < 128 ? 0 : pat(n - 128));
      chk("R4 rd_fs after align", rd_fs, n == 128);
    end
    strobes(0, 0, 0, 0);
    align_cmd = 1'b0;

    // R9 pointer reset restores full-frame spacing
    do_reset();
    for (int k = 0; k < 100; k++) begin
      strobes(0, 1, 0, 0);
      tick();
    end
    reset_cmd = 1'b1;
    tick();
    reset_cmd = 1'b0;
    strobes(0, 0, 0, 0);
    stream(300, 256, 0, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule